// File: doc/BRIEF.md
# Radio power-cycle reset sequencer

This block brings an external radio module up and down through a fixed order of pin levels. It drives a supply-disable line (high removes power), three SPI lines (MOSI, SCLK, an active-low chip select), a sleep/transmit control line, and one output enable shared by those interface pins. It does no SPI traffic and does not contain the analog supply switch. The block only makes sure that no interface pin back-feeds a rail at the wrong moment and that every wait is long enough.

Three one-cycle command inputs are available. Open powers the module up for the first time, cycle performs a full power cycle, and close cuts power and floats the pins. While a sequence runs, `busy_o` is high. A single-cycle `done_o` marks its end. Every wait is a whole number of milliseconds, converted to clock cycles from the clock-frequency parameter.

Top module: `rpwr_seq`

## Requirements
- R1: After reset the block is in the released state: pin_oe_o=0, vdd_off_o=1, mosi_o=sclk_o=csn_o=slptr_o=0, busy_o=0, done_o=0, and it stays there with no command.
- R2: In the first cycle after a cycle command is accepted, mosi_o, sclk_o, csn_o and slptr_o are all 0 and pin_oe_o=1, while vdd_off_o keeps its previous value; power is cut only in a later cycle.
- R3: After that cycle, vdd_off_o=1 with all four interface lines low for exactly DRAIN_CYC cycles (drain wait, nominal 100 ms).
- R4: Next, mosi_o=1 and csn_o=1 with vdd_off_o=1 and sclk_o=slptr_o=0 for exactly PRE_CYC cycles (precharge, nominal 10 ms).
- R5: Next, vdd_off_o=0 with mosi_o=1 and csn_o=1 for exactly 2*RAMP_CYC cycles (ramp wait plus the extra reset wait, each nominally 10 ms).
- R6: The powered idle state has pin_oe_o=1, vdd_off_o=0, csn_o=1 and mosi_o=sclk_o=slptr_o=0.
- R7: An open command gives csn_o=1, vdd_off_o=1, mosi_o=sclk_o=slptr_o=0 with pin_oe_o=1 for PRE_CYC cycles. It then gives vdd_off_o=0 with csn_o=1 for RAMP_CYC cycles, and then enters the powered idle state.
- R8: A close command gives one busy cycle with vdd_off_o=1 and pin_oe_o=0, after which the block returns to the released state of R1. Whenever pin_oe_o=0, vdd_off_o=1.
- R9: busy_o is 1 in every cycle from the one after the accepting clock edge to the last cycle of the sequence. done_o is 1 for exactly one cycle, the first idle cycle, in which busy_o is 0.
- R10: Any command that arrives while busy_o=1 is ignored, and the running sequence keeps its timing and pin levels.
- R11: Commands arriving in the same idle cycle are resolved with close first, then cycle, then open.
- R12: Each wait lasts (CLK_HZ/1000)*MS cycles for its MS parameter (DRAIN_MS, PRE_MS, RAMP_MS). Each such count must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_i | input | 1 | Open command, one-cycle pulse |
| cycle_i | input | 1 | Power-cycle command, one-cycle pulse |
| close_i | input | 1 | Close command, one-cycle pulse |
| pin_oe_o | output | 1 | Drive enable for MOSI, SCLK, chip select and sleep/transmit |
| vdd_off_o | output | 1 | Supply disable, 1 removes power |
| mosi_o | output | 1 | MOSI level |
| sclk_o | output | 1 | SCLK level |
| csn_o | output | 1 | Chip select level (active low) |
| slptr_o | output | 1 | Sleep/transmit control level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume that every derived wait count is nonzero, so a timer load never wraps. They also assume that reset is asserted at time zero. The bench uses a small clock-frequency setting, which makes the drain, precharge and ramp counts different short values. It holds reset from the first cycle and issues commands only as one-cycle pulses placed between clock edges. Commands that must be ignored are injected at several points inside a running sequence, including its final busy cycle.

// File: rtl/rpwr_pkg.sv
package rpwr_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_READY, ST_LOW, ST_CUT, ST_PRE, ST_UP1, ST_UP2,
    ST_OPRE, ST_OUP, ST_CLOSE
  } rpwr_state_e;

  typedef struct packed {
    logic oe;
    logic vdd_off;
    logic mosi;
    logic sclk;
    logic csn;
    logic slptr;
  } rpwr_pins_t;

  function automatic logic is_idle(rpwr_state_e s);
    return (s == ST_OFF) || (s == ST_READY);
  endfunction
endpackage

// File: rtl/rpwr_timer.sv
module rpwr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= val_i - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (val_i != '0)); // R12
endmodule

// File: rtl/rpwr_fsm.sv
module rpwr_fsm
  import rpwr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DRAIN_CYC = 100,
  parameter int PRE_CYC   = 10,
  parameter int RAMP_CYC  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             cycle_i,
  input  logic             close_i,
  input  logic             zero_i,
  output rpwr_state_e      state_d,
  output logic             load_o,
  output logic [CNT_W-1:0] val_o
);
  rpwr_state_e state_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    val_o   = '0;
    case (state_q)
      ST_OFF, ST_READY: begin
        if (close_i)
          state_d = ST_CLOSE;
        else if (cycle_i)
          state_d = ST_LOW;
        else if (open_i) begin
          state_d = ST_OPRE;
          load_o  = 1'b1;
          val_o   = CNT_W'(PRE_CYC);
        end
      end
      ST_LOW: begin
        state_d = ST_CUT;
        load_o  = 1'b1;
        val_o   = CNT_W'(DRAIN_CYC);
      end
      ST_CUT: if (zero_i) begin
        state_d = ST_PRE;
        load_o  = 1'b1;
        val_o   = CNT_W'(PRE_CYC);
      end
      ST_PRE: if (zero_i) begin
        state_d = ST_UP1;
        load_o  = 1'b1;
        val_o   = CNT_W'(RAMP_CYC);
      end
      ST_UP1: if (zero_i) begin
        state_d = ST_UP2;
        load_o  = 1'b1;
        val_o   = CNT_W'(RAMP_CYC);
      end
      ST_UP2:  if (zero_i) state_d = ST_READY;
      ST_OPRE: if (zero_i) begin
        state_d = ST_OUP;
        load_o  = 1'b1;
        val_o   = CNT_W'(RAMP_CYC);
      end
      ST_OUP:   if (zero_i) state_d = ST_READY;
      ST_CLOSE: state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_d;
  end

  AST_CUT_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CUT && $past(state_q) != ST_CUT) |-> $past(state_q) == ST_LOW); // R2
  AST_UP_FROM_PRE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP1 && $past(state_q) != ST_UP1) |-> $past(state_q) == ST_PRE); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!is_idle(state_q) && !zero_i && state_q != ST_LOW && state_q != ST_CLOSE)
      |=> state_q == $past(state_q)); // R10
endmodule

// File: rtl/rpwr_pins.sv
module rpwr_pins
  import rpwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  rpwr_state_e state_d,
  output rpwr_pins_t  pins_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam rpwr_pins_t RELEASED = '{oe: 1'b0, vdd_off: 1'b1, default: 1'b0};

  rpwr_pins_t pins_d;

  always_comb begin
    pins_d = '{oe: 1'b1, vdd_off: 1'b1, default: 1'b0};
    case (state_d)
      ST_OFF, ST_CLOSE: pins_d = RELEASED;
      ST_READY: begin pins_d.vdd_off = 1'b0; pins_d.csn = 1'b1; end
      ST_LOW:   pins_d.vdd_off = pins_o.vdd_off;
      ST_CUT:   ;
      ST_PRE:   begin pins_d.mosi = 1'b1; pins_d.csn = 1'b1; end
      ST_UP1, ST_UP2: begin
        pins_d.vdd_off = 1'b0; pins_d.mosi = 1'b1; pins_d.csn = 1'b1;
      end
      ST_OPRE:  pins_d.csn = 1'b1;
      ST_OUP:   begin pins_d.vdd_off = 1'b0; pins_d.csn = 1'b1; end
      default:  pins_d = RELEASED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_o <= RELEASED;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      pins_o <= pins_d;
      busy_o <= !is_idle(state_d);
      done_o <= busy_o && is_idle(state_d);
    end
  end

  AST_HIZ_POWER_OFF: assert property (@(posedge clk) disable iff (rst)
    !pins_o.oe |-> pins_o.vdd_off); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_CUT_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(pins_o.vdd_off) && !pins_o.csn) |-> (!pins_o.mosi && !pins_o.sclk && !pins_o.slptr)); // R3
endmodule

// File: rtl/rpwr_seq.sv
module rpwr_seq
  import rpwr_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int DRAIN_MS = 100,
  parameter int PRE_MS   = 10,
  parameter int RAMP_MS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  logic cycle_i,
  input  logic close_i,
  output logic pin_oe_o,
  output logic vdd_off_o,
  output logic mosi_o,
  output logic sclk_o,
  output logic csn_o,
  output logic slptr_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int DRAIN_CYC  = CYC_PER_MS * DRAIN_MS;
  localparam int PRE_CYC    = CYC_PER_MS * PRE_MS;
  localparam int RAMP_CYC   = CYC_PER_MS * RAMP_MS;
  localparam int MAX_A      = (DRAIN_CYC > PRE_CYC) ? DRAIN_CYC : PRE_CYC;
  localparam int MAX_CYC    = (MAX_A > RAMP_CYC) ? MAX_A : RAMP_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  rpwr_state_e      state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  rpwr_pins_t       pins;

  rpwr_fsm #(
    .CNT_W(CNT_W), .DRAIN_CYC(DRAIN_CYC), .PRE_CYC(PRE_CYC), .RAMP_CYC(RAMP_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .open_i(open_i), .cycle_i(cycle_i), .close_i(close_i),
    .zero_i(zero), .state_d(state_d), .load_o(load), .val_o(load_val)
  );

  rpwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(load), .val_i(load_val), .zero_o(zero)
  );

  rpwr_pins u_pins (
    .clk(clk), .rst(rst), .state_d(state_d), .pins_o(pins),
    .busy_o(busy_o), .done_o(done_o)
  );

  assign pin_oe_o  = pins.oe;
  assign vdd_off_o = pins.vdd_off;
  assign mosi_o    = pins.mosi;
  assign sclk_o    = pins.sclk;
  assign csn_o     = pins.csn;
  assign slptr_o   = pins.slptr;
endmodule

// File: tb/rpwr_seq_bench.sv
`timescale 1ns/1ps
module rpwr_seq_bench;
  localparam int CLK_HZ = 3000, DRAIN_MS = 5, PRE_MS = 2, RAMP_MS = 1;
  localparam int D = (CLK_HZ / 1000) * DRAIN_MS;  // R12
  localparam int P = (CLK_HZ / 1000) * PRE_MS;
  localparam int R = (CLK_HZ / 1000) * RAMP_MS;

  logic clk = 1'b0, rst = 1'b1, open_i = 1'b0, cycle_i = 1'b0, close_i = 1'b0;
  logic pin_oe_o, vdd_off_o, mosi_o, sclk_o, csn_o, slptr_o, busy_o, done_o;
  int n_chk = 0, n_fail = 0;
  logic m_vdd = 1'b1;
  bit finished = 0;

  always #4 clk = ~clk;

  rpwr_seq #(.CLK_HZ(CLK_HZ), .DRAIN_MS(DRAIN_MS), .PRE_MS(PRE_MS), .RAMP_MS(RAMP_MS)) u_rpwr_seq (
    .clk(clk), .rst(rst), .open_i(open_i), .cycle_i(cycle_i), .close_i(close_i),
    .pin_oe_o(pin_oe_o), .vdd_off_o(vdd_off_o), .mosi_o(mosi_o), .sclk_o(sclk_o),
    .csn_o(csn_o), .slptr_o(slptr_o), .busy_o(busy_o), .done_o(done_o)
  );

  // vector order: {oe, vdd_off, mosi, sclk, csn, slptr, busy, done}
  function automatic logic [7:0] actual();
    return {pin_oe_o, vdd_off_o, mosi_o, sclk_o, csn_o, slptr_o, busy_o, done_o};
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    n_chk++;
    if (actual() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, actual(), exp);
    end
  endtask

  // kind 0 = cycle, 1 = open, 2 = close; k counts cycles after the accepting edge
  task automatic expect_at(input int kind, input int k, input logic vdd0,
                           output logic [7:0] e, output string tag);
    int t;
    if (kind == 2) begin
      if (k == 1) begin e = 8'b01_0000_10; tag = "R8 close"; end
      else begin e = {7'b01_0000_0, k == 2}; tag = "R8 R1 released after close"; end
    end else if (kind == 1) begin
      t = P + R;
      if (k <= P)      begin e = 8'b11_0010_10; tag = "R7 R12 open precharge"; end
      else if (k <= t) begin e = 8'b10_0010_10; tag = "R7 R12 open ramp"; end
      else begin e = {7'b10_0010_0, k == t + 1}; tag = "R6 R9 ready after open"; end
    end else begin
      t = 1 + D + P + 2 * R;
      if (k == 1)              begin e = {1'b1, vdd0, 6'b0000_10}; tag = "R2 lines low"; end
      else if (k <= 1 + D)     begin e = 8'b11_0000_10; tag = "R3 R12 drain"; end
      else if (k <= 1 + D + P) begin e = 8'b11_1010_10; tag = "R4 R12 precharge"; end
      else if (k <= t)         begin e = 8'b10_1010_10; tag = "R5 R12 power-up"; end
      else begin e = {7'b10_0010_0, k == t + 1}; tag = "R6 R9 ready after cycle"; end
    end
  endtask

  task automatic run(input logic [2:0] cmd, input int kind, input int inj1, input int inj2,
                     input logic [2:0] injcmd);
    logic [7:0] e;
    string tag;
    int total;
    logic vdd0;
    vdd0 = m_vdd;
    total = (kind == 2) ? 1 : (kind == 1) ? P + R : 1 + D + P + 2 * R;
    {close_i, cycle_i, open_i} = cmd;
    for (int k = 1; k <= total + 2; k++) begin
      @(negedge clk);
      {close_i, cycle_i, open_i} = 3'b000;
      expect_at(kind, k, vdd0, e, tag);
      if (k == inj1 || k == inj2) tag = {tag, " R10 ignored"};
      check(e, tag);
      if (k == inj1 || k == inj2) {close_i, cycle_i, open_i} = injcmd;
    end
    m_vdd = (kind == 2) ? 1'b1 : 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(8'b01_0000_00, "R1 reset state");
    end
    run(3'b001, 1, 0, 0, 3'b000);                 // open from released
    run(3'b010, 0, 3, D + 2, 3'b100);             // cycle from ready, close injected
    run(3'b010, 0, 1, 1 + D + P + 2 * R, 3'b011); // cycle again, cycle/open injected
    run(3'b100, 2, 1, 0, 3'b010);                 // close, cycle injected in its busy cycle
    run(3'b010, 0, 0, 0, 3'b000);                 // R2 cycle from released keeps vdd_off high
    run(3'b001, 1, P, P + R, 3'b100);             // open from ready with injections
    run(3'b111, 2, 0, 0, 3'b000);                 // R11 close wins
    run(3'b011, 0, 0, 0, 3'b000);                 // R11 cycle beats open
    repeat (3) begin
      @(negedge clk);
      check(8'b10_0010_00, "R6 ready holds");
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule